// File: doc/BRIEF.md
# Serial Status Register Readout Controller

This block holds a 16-bit sticky status word that collects failure and status events. A host reads the word one bit at a time, with no separate clock line. It toggles a single enable input, and every transition of that input, rising or falling, steps a bit pointer. The selected bit appears on an active-low error output. When the host leaves the enable input alone for a configurable number of system clocks, readout ends. The block then adopts the operating mode that the enable and standby inputs encode at that moment.

Status bits are only cleared by a deliberate host sequence. First, the host must command entry into normal mode. After that, it must clock a complete, uninterrupted pass over all bits. The clear is applied on the transition that wraps the pointer from the last bit back to bit 0, so a continued readout shows the cleared state on its second pass. A bit whose live root-cause input is still active survives the clear. An event that arrives in the same cycle as the clear also keeps its bit set.

Top module: `stat_serial_rd`

## Requirements
- R1: After reset, readout is inactive, the mode output is standby (2'b00), the status word is empty, and `err_n_o` is high.
- R2: `en_i` and `sby_i` each pass through a two-stage synchronizer. While readout is inactive, a transition of `en_i` in either direction enters readout with the pointer at bit 0, and `rd_act_o` goes high on the third rising clock edge after the change.
- R3: While readout is active, each further transition of `en_i` advances the pointer by one, and `mode_o` stays unchanged.
- R4: While readout is active, `err_n_o` is the inverse of the status bit at the pointer (low when that bit is set).
- R5: While readout is inactive, `err_n_o` is low exactly when at least one status bit is set.
- R6: Readout ends on the edge on which `TIMEOUT` consecutive system clocks have passed without a synchronized enable transition. `mode_o` is then set from the synchronized inputs: standby low gives standby (2'b00); standby high with enable low gives receive-only (2'b01); standby high with enable high gives normal (2'b10).
- R7: A high `evt_i[k]` in any cycle sets status bit k, and the bit then stays set until a successful clear.
- R8: A clear happens only on the transition that moves the pointer from bit 15 to bit 0, and only if an exit into normal mode has occurred since the last clear. A readout abandoned before that transition clears nothing.
- R9: After bit 15, the next transition wraps the pointer to bit 0. On the second pass, the bits removed by the clear read as clear.
- R10: During a clear, bit k is kept if `cause_i[k]` is high and is removed if it is low.
- R11: An event on bit k in the same cycle as a clear leaves bit k set.
- R12: A clear uses up the normal-mode arming, so a later full pass without a new normal-mode exit clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Host enable; its transitions clock the readout |
| sby_i | input | 1 | Host standby select, sampled at readout exit |
| evt_i | input | NBITS | Per-bit event pulses that set status bits |
| cause_i | input | NBITS | Per-bit live root-cause levels that block a clear |
| err_n_o | output | 1 | Selected bit during readout, otherwise aggregated error, active low |
| rd_act_o | output | 1 | High while readout is active |
| mode_o | output | 2 | Operating mode: 00 standby, 01 receive-only, 10 normal |

## Verification
The bench builds the block with `NBITS` = 16, `SYNC_STAGES` = 2 and `TIMEOUT` = 12. The short timeout lets a single run exit readout several times and pass through all three modes. With 16 bits, a 17-transition pass reaches the wrap, so the bench can drive an event in exactly the wrap cycle, cover a clear with a cause held, and show a second pass. A behavioural reference model compares the error, readout-active and mode outputs on every clock.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic [1:0] {
      MODE_STBY = 2'b00,
      MODE_RXO  = 2'b01,
      MODE_NORM = 2'b10
   } ssr_mode_e;
endpackage

// File: rtl/ssr_sync.sv
// Multi-stage level synchronizer for a small bundle of asynchronous inputs.
module ssr_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial begin
      assert (STAGES >= 2) else $error("ssr_sync: STAGES must be at least 2");
      assert (W >= 1) else $error("ssr_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssr_seq.sv
// Readout sequencer: edge detect, bit pointer, quiet timeout, exit mode, clear arming.
module ssr_seq
   import ssr_pkg::*;
#(
   parameter int NBITS   = 16,
   parameter int TIMEOUT = 1000,
   localparam int PTR_W  = $clog2(NBITS),
   localparam int CNT_W  = $clog2(TIMEOUT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_s,
   input  logic             sby_s,
   output logic             rd_act_o,
   output logic [PTR_W-1:0] ptr_o,
   output logic             clr_o,
   output ssr_mode_e        mode_o
);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBITS - 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

   initial begin
      assert (NBITS >= 2) else $error("ssr_seq: NBITS must be at least 2");
      assert (TIMEOUT >= 2) else $error("ssr_seq: TIMEOUT must be at least 2");
   end

   logic             en_d;
   logic             tgl;
   logic             rd_q, rd_n;
   logic [PTR_W-1:0] ptr_q, ptr_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   ssr_mode_e        mode_q, mode_n, sel;
   logic             arm_q, arm_n;
   logic             clr;

   assign tgl = en_s ^ en_d;

   always_comb begin
      if (!sby_s)    sel = MODE_STBY;
      else if (en_s) sel = MODE_NORM;
      else           sel = MODE_RXO;
   end

   always_comb begin
      rd_n   = rd_q;
      ptr_n  = ptr_q;
      cnt_n  = cnt_q;
      mode_n = mode_q;
      arm_n  = arm_q;
      clr    = 1'b0;
      if (rd_q) begin
         if (tgl) begin
            cnt_n = '0;
            if (ptr_q == PTR_LAST) begin
               ptr_n = '0;
               if (arm_q) begin
                  clr   = 1'b1;
                  arm_n = 1'b0;
               end
            end else begin
               ptr_n = ptr_q + 1'b1;
            end
         end else if (cnt_q == CNT_LAST) begin
            rd_n   = 1'b0;
            cnt_n  = '0;
            mode_n = sel;
            if (sel == MODE_NORM) arm_n = 1'b1;
         end else begin
            cnt_n = cnt_q + 1'b1;
         end
      end else if (tgl) begin
         rd_n  = 1'b1;
         ptr_n = '0;
         cnt_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d   <= 1'b0;
         rd_q   <= 1'b0;
         ptr_q  <= '0;
         cnt_q  <= '0;
         mode_q <= MODE_STBY;
         arm_q  <= 1'b0;
      end else begin
         en_d   <= en_s;
         rd_q   <= rd_n;
         ptr_q  <= ptr_n;
         cnt_q  <= cnt_n;
         mode_q <= mode_n;
         arm_q  <= arm_n;
      end
   end

   assign rd_act_o = rd_q;
   assign ptr_o    = ptr_q;
   assign clr_o    = clr;
   assign mode_o   = mode_q;
endmodule

// File: rtl/ssr_store.sv
// Sticky status bits with cause-qualified clear; a same-cycle event wins.
module ssr_store #(
   parameter int NBITS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] evt_i,
   input  logic [NBITS-1:0] cause_i,
   input  logic             clr_i,
   output logic [NBITS-1:0] stat_o
);
   for (genvar k = 0; k < NBITS; k++) begin : g_bit
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      b_q <= 1'b0;
         else if (evt_i[k])               b_q <= 1'b1;
         else if (clr_i && !cause_i[k])   b_q <= 1'b0;
      end
      assign stat_o[k] = b_q;
   end
endmodule

// File: rtl/stat_serial_rd.sv
module stat_serial_rd
   import ssr_pkg::*;
#(
   parameter int NBITS       = 16,
   parameter int TIMEOUT     = 1000,
   parameter int SYNC_STAGES = 2,
   localparam int PTR_W      = $clog2(NBITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             sby_i,
   input  logic [NBITS-1:0] evt_i,
   input  logic [NBITS-1:0] cause_i,
   output logic             err_n_o,
   output logic             rd_act_o,
   output logic [1:0]       mode_o
);
   initial begin
      assert (NBITS == (1 << PTR_W)) else $error("stat_serial_rd: NBITS must be a power of two");
   end

   logic [1:0]       sync_q;
   logic             en_s, sby_s;
   logic             rd_act;
   logic [PTR_W-1:0] ptr;
   logic             clr;
   ssr_mode_e        mode;
   logic [NBITS-1:0] stat;

   ssr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sby_i, en_i}),
      .q_o   (sync_q)
   );

   assign en_s  = sync_q[0];
   assign sby_s = sync_q[1];

   ssr_seq #(.NBITS(NBITS), .TIMEOUT(TIMEOUT)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_s     (en_s),
      .sby_s    (sby_s),
      .rd_act_o (rd_act),
      .ptr_o    (ptr),
      .clr_o    (clr),
      .mode_o   (mode)
   );

   ssr_store #(.NBITS(NBITS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i),
      .cause_i (cause_i),
      .clr_i   (clr),
      .stat_o  (stat)
   );

   assign err_n_o  = rd_act ? ~stat[ptr] : ~(|stat);
   assign rd_act_o = rd_act;
   assign mode_o   = mode;
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
   parameter int NBITS   = 16,
   parameter int TIMEOUT = 1000,
   localparam int PTR_W  = $clog2(NBITS),
   localparam int Q_W    = $clog2(TIMEOUT) + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_s,
   input logic             rd_act,
   input logic [PTR_W-1:0] ptr,
   input logic [1:0]       mode,
   input logic [NBITS-1:0] stat,
   input logic [NBITS-1:0] evt,
   input logic [NBITS-1:0] cause,
   input logic             clr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NBITS - 1);
   localparam logic [Q_W-1:0]   QMAX = Q_W'(TIMEOUT);

   logic           en_prev;
   logic           tgl;
   logic [Q_W-1:0] quiet;

   assign tgl = en_s ^ en_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev <= 1'b0;
         quiet   <= '0;
      end else begin
         en_prev <= en_s;
         if (!rd_act || tgl) quiet <= '0;
         else                quiet <= quiet + 1'b1;
      end
   end

   AST_PTR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_act) |-> ptr == '0); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && tgl && ptr != LAST) |=> ptr == $past(ptr) + 1'b1); // R3
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_act |-> $stable(mode)); // R3
   AST_QUIET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_act |-> quiet < QMAX); // R6
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (stat & $past(stat)) == $past(stat)); // R7
   AST_CLR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> (rd_act && tgl && ptr == LAST)); // R8
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && tgl && ptr == LAST) |=> ptr == '0); // R9
   AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (stat & $past(stat & cause)) == $past(stat & cause)); // R10
   AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> (stat & $past(evt)) == $past(evt)); // R11
endmodule

bind stat_serial_rd ssr_chk #(.NBITS(NBITS), .TIMEOUT(TIMEOUT)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en_s   (en_s),
   .rd_act (rd_act),
   .ptr    (ptr),
   .mode   (mode_o),
   .stat   (stat),
   .evt    (evt_i),
   .cause  (cause_i),
   .clr    (clr)
);

// File: tb/stat_serial_rd_test.sv
module stat_serial_rd_test;
   localparam int CLK_P = 10;
   localparam int NB    = 16;
   localparam int TMO   = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_i = 1'b0;
   logic          sby_i = 1'b0;
   logic [NB-1:0] evt_i = '0;
   logic [NB-1:0] cause_i = '0;
   logic          err_n_o;
   logic          rd_act_o;
   logic [1:0]    mode_o;

   int n_tot = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   stat_serial_rd #(.NBITS(NB), .TIMEOUT(TMO), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .sby_i(sby_i),
      .evt_i(evt_i), .cause_i(cause_i),
      .err_n_o(err_n_o), .rd_act_o(rd_act_o), .mode_o(mode_o)
   );

   // Behavioural reference model
   logic          m_s1 = 0, m_s2 = 0, m_sd = 0, m_b1 = 0, m_b2 = 0;
   logic          m_rd = 0, m_arm = 0;
   int            m_ptr = 0, m_cnt = 0, m_mode = 0;
   logic [NB-1:0] m_stat = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_sd = 0; m_b1 = 0; m_b2 = 0;
         m_rd = 0; m_arm = 0; m_ptr = 0; m_cnt = 0; m_mode = 0; m_stat = '0;
      end else begin
         logic edg, do_clr;
         edg = m_s2 ^ m_sd;
         do_clr = 0;
         if (m_rd) begin
            if (edg) begin
               m_cnt = 0;
               if (m_ptr == NB-1) begin
                  m_ptr = 0;
                  if (m_arm) begin do_clr = 1; m_arm = 0; end
               end else m_ptr = m_ptr + 1;
            end else if (m_cnt == TMO-1) begin
               m_rd = 0; m_cnt = 0;
               m_mode = !m_b2 ? 0 : (m_s2 ? 2 : 1);
               if (m_mode == 2) m_arm = 1;
            end else m_cnt = m_cnt + 1;
         end else if (edg) begin
            m_rd = 1; m_ptr = 0; m_cnt = 0;
         end
         if (do_clr) m_stat = m_stat & cause_i;
         m_stat = m_stat | evt_i;
         m_sd = m_s2; m_s2 = m_s1; m_s1 = en_i;
         m_b2 = m_b1; m_b1 = sby_i;
      end
   end

   task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk({3'b0, err_n_o}, {3'b0, (m_rd ? ~m_stat[m_ptr] : ~(|m_stat))},
             m_rd ? "R4 model err_n" : "R5 model err_n");
         chk({3'b0, rd_act_o}, {3'b0, m_rd}, "R6 model rd_act");
         chk({2'b0, mode_o}, 4'(m_mode), "R6 model mode");
      end
   end

   task automatic tgl(input int n);
      for (int i = 0; i < n; i++) begin
         en_i = ~en_i;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic tgl_evt(input logic [NB-1:0] mask);
      en_i = ~en_i;
      @(negedge clk);
      @(negedge clk);
      evt_i = mask;
      @(negedge clk);
      evt_i = '0;
      @(negedge clk);
   endtask

   task automatic settle;
      repeat (TMO + 6) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tot++; n_bad++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({3'b0, rd_act_o}, 4'd0, "R1 reset rd_act");
      chk({2'b0, mode_o}, 4'd0, "R1 reset mode");
      chk({3'b0, err_n_o}, 4'd1, "R1 reset err_n");

      evt_i = (NB'(1) << 3) | (NB'(1) << 15);
      @(negedge clk);
      evt_i = '0;
      repeat (2) @(negedge clk);
      chk({3'b0, err_n_o}, 4'd0, "R7 R5 event latched, aggregate low");

      // A: standby readout, entry timing, full pass without arming
      en_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk({3'b0, rd_act_o}, 4'd0, "R2 not yet active after two edges");
      @(negedge clk);
      chk({3'b0, rd_act_o}, 4'd1, "R2 active on third edge");
      chk({3'b0, err_n_o}, 4'd1, "R4 bit0 clear");
      @(negedge clk);
      tgl(3);
      chk({3'b0, err_n_o}, 4'd0, "R4 bit3 set");
      tgl(12);
      chk({3'b0, err_n_o}, 4'd0, "R3 bit15 set");
      tgl(1);
      chk({3'b0, err_n_o}, 4'd1, "R9 wrapped to bit0");
      settle();
      chk({2'b0, mode_o}, 4'd0, "R6 exit to standby");
      chk({3'b0, err_n_o}, 4'd0, "R8 no clear without normal entry");

      // B: mode selection
      sby_i = 1'b1;
      tgl(1);
      settle();
      chk({2'b0, mode_o}, 4'd1, "R6 exit to receive-only");
      tgl(1);
      settle();
      chk({2'b0, mode_o}, 4'd2, "R6 exit to normal");

      // C: aborted readout
      tgl(5);
      settle();
      chk({2'b0, mode_o}, 4'd1, "R6 exit receive-only after abort");

      // D: full pass with cause held on bit15 and event on bit7 at the clear
      cause_i = NB'(1) << 15;
      tgl(4);
      chk({3'b0, err_n_o}, 4'd0, "R8 abort kept bit3");
      tgl(12);
      tgl_evt(NB'(1) << 7);
      chk({3'b0, err_n_o}, 4'd1, "R9 second pass bit0");
      tgl(3);
      chk({3'b0, err_n_o}, 4'd1, "R9 R10 bit3 cleared");
      tgl(4);
      chk({3'b0, err_n_o}, 4'd0, "R11 bit7 event won over clear");
      tgl(8);
      chk({3'b0, err_n_o}, 4'd0, "R10 bit15 kept by cause");
      settle();

      // E: arming consumed
      cause_i = '0;
      tgl(24);
      chk({3'b0, err_n_o}, 4'd0, "R12 bit7 survives unarmed pass");
      settle();
      chk({2'b0, mode_o}, 4'd1, "R6 receive-only after pass");

      // F: re-arm and clear everything
      tgl(1);
      settle();
      chk({2'b0, mode_o}, 4'd2, "R6 normal re-entry");
      tgl(17);
      settle();
      chk({3'b0, err_n_o}, 4'd1, "R8 all bits cleared");
      chk({2'b0, mode_o}, 4'd1, "R6 final mode");

      $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
      $finish;
   end
endmodule